// File: doc/BRIEF.md
# DRAM refresh and initialization sequencer

This block keeps an asynchronous DRAM array alive. After reset it waits out a power-up delay. It then runs a burst of refresh cycles, and only after that does it report the array ready for use. From then on, a free-running interval timer asks for one refresh per refresh interval. Every refresh uses the CAS-before-RAS form, so no row address is needed: CAS falls, then RAS falls, CAS is released, RAS is released, and the strobes then precharge. The write strobe stays high the whole time, so a refresh can never fall into the array's test mode.

The block shares the DRAM bus with a host access controller through a level handshake. It raises `refresh_req` when it has work and starts a strobe sequence only after `bus_grant` is seen high. It keeps the request high until one cycle after the precharge ends. Intervals that pass while the bus is withheld are counted in a small saturating backlog, and the backlog is worked off back to back once the bus is granted. If a tick arrives while the backlog is full, a sticky error flag is set.

All timing is given in nanoseconds and converted to clock counts from `CLK_NS`. `SPEED_GRADE` picks the 60 ns set of DRAM minimums (0) or the 70 ns set (1).

Top module: `dram_refresh_seq`

## Requirements
- R1: During and straight after reset, `ras_n`, `cas_n` and `we_n` are high, and `refresh_req`, `array_ready` and `backlog_overflow` are low.
- R2: `refresh_req` stays low for the first ceil(POWERUP_NS/CLK_NS) cycles after reset is released, and rises within four cycles after that.
- R3: `array_ready` rises only after exactly INIT_CYCLES refresh cycles (falling edges of `ras_n`) have been issued since reset. Once high, it stays high.
- R4: `ras_n` and `cas_n` are low only while both `refresh_req` and `bus_grant` are high. No strobe moves while `bus_grant` is low. `refresh_req` falls only after both strobes have been high for at least two cycles.
- R5: In every refresh cycle `cas_n` falls before `ras_n` and stays low for at least ceil(5 ns/CLK_NS) cycles before `ras_n` falls.
- R6: `cas_n` stays low for at least ceil(tCHR/CLK_NS) cycles after `ras_n` falls. tCHR is 10 ns for grade 0 and 15 ns for grade 1.
- R7: `ras_n` stays low for at least ceil(tRAS/CLK_NS) cycles. tRAS is 60 ns for grade 0 and 70 ns for grade 1.
- R8: Between refresh cycles, `ras_n` is high for at least ceil(max(tRP, 5 ns)/CLK_NS) cycles before `cas_n` falls again. tRP is 40 ns for grade 0 and 50 ns for grade 1.
- R9: `we_n` is high in every cycle.
- R10: Once ready, with the bus always granted, the block issues one refresh per ceil(REFRESH_NS/CLK_NS) cycles.
- R11: Intervals that pass while the bus is withheld are remembered. When the bus is granted, the block issues that many refresh cycles back to back.
- R12: The backlog saturates at PEND_DEPTH. A tick that arrives while the backlog is full sets `backlog_overflow`, which then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_grant | input | 1 | Host controller hands the DRAM bus to the sequencer |
| refresh_req | output | 1 | Sequencer wants the DRAM bus |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, held high |
| array_ready | output | 1 | Power-up wait and initialization burst are done |
| backlog_overflow | output | 1 | Sticky: a refresh interval was lost |

## Verification
The checker assumes the host keeps `bus_grant` high from the moment it grants until `refresh_req` drops, and never withdraws the bus in the middle of a strobe sequence. The stimulus follows this rule: it lowers `bus_grant` only while `refresh_req` is low, and raises it at any time. The width checks also assume the power-up wait is at least as long as the precharge time, so the first CAS fall after reset already meets R8. The bench configuration satisfies this.

// File: rtl/drs_pkg.sv
package drs_pkg;

   typedef enum logic [2:0] {
      ST_PWR,
      ST_IDLE,
      ST_REQ,
      ST_CBR,
      ST_HOLD,
      ST_RASLO,
      ST_PRE,
      ST_DONE
   } seq_state_t;

   // ceiling division, never below one cycle
   function automatic int ns_to_cyc(input int ns, input int per);
      int c;
      c = (ns + per - 1) / per;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int t_ras_ns(input int grade);
      return (grade != 0) ? 70 : 60;
   endfunction

   function automatic int t_chr_ns(input int grade);
      return (grade != 0) ? 15 : 10;
   endfunction

   function automatic int t_rp_ns(input int grade);
      return (grade != 0) ? 50 : 40;
   endfunction

   localparam int T_CSR_NS = 5;
   localparam int T_RPC_NS = 5;

endpackage

// File: rtl/drs_interval_timer.sv
module drs_interval_timer #(
   parameter int PERIOD = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);
   localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

   logic [CW-1:0] cnt;
   logic          at_end;

   assign at_end = (cnt == CW'(PERIOD - 1));
   assign tick   = en && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!en || at_end)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/drs_backlog.sv
module drs_backlog #(
   parameter int DEPTH = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inc,
   input  logic dec,
   output logic nonzero,
   output logic overflow
);
   logic full;
   logic ovf_q;

   generate
      if (DEPTH == 1) begin : g_flag
         logic flag;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               flag <= 1'b0;
            else if (inc)
               flag <= 1'b1;
            else if (dec)
               flag <= 1'b0;
         end
         assign nonzero = flag;
         assign full    = flag && !dec;
      end else begin : g_count
         localparam int PW = $clog2(DEPTH + 1);
         logic [PW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt <= '0;
            else if (inc && !dec && cnt != PW'(DEPTH))
               cnt <= cnt + 1'b1;
            else if (dec && !inc && cnt != '0)
               cnt <= cnt - 1'b1;
         end
         assign nonzero = (cnt != '0);
         assign full    = (cnt == PW'(DEPTH)) && !dec;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ovf_q <= 1'b0;
      else if (inc && full)
         ovf_q <= 1'b1;
   end

   assign overflow = ovf_q;
endmodule

// File: rtl/drs_strobe_fsm.sv
module drs_strobe_fsm
   import drs_pkg::*;
#(
   parameter int INIT_CYCLES = 8,
   parameter int CSR_CYC     = 1,
   parameter int CHR_CYC     = 2,
   parameter int RASO_CYC    = 10,
   parameter int RP_CYC      = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_done,
   input  logic ref_due,
   input  logic grant,
   output logic in_pwr,
   output logic req,
   output logic ras_n,
   output logic cas_n,
   output logic ready,
   output logic svc_done
);
   localparam int M1   = (CSR_CYC > CHR_CYC) ? CSR_CYC : CHR_CYC;
   localparam int M2   = (RASO_CYC > RP_CYC) ? RASO_CYC : RP_CYC;
   localparam int MAXC = (M1 > M2) ? M1 : M2;
   localparam int CW   = $clog2(MAXC + 1);
   localparam int IW   = $clog2(INIT_CYCLES + 1);

   seq_state_t    st, st_n;
   logic [CW-1:0] cnt, cnt_n;
   logic [IW-1:0] init_left;
   logic          work;
   logic          ras_q, cas_q, req_q;

   assign work = (init_left != '0) || ref_due;

   always_comb begin
      st_n  = st;
      cnt_n = (cnt != '0) ? cnt - 1'b1 : cnt;
      unique case (st)
         ST_PWR:   if (pwr_done) st_n = ST_IDLE;
         ST_IDLE:  if (work)     st_n = ST_REQ;
         ST_REQ:   if (grant) begin
                      st_n  = ST_CBR;
                      cnt_n = CW'(CSR_CYC - 1);
                   end
         ST_CBR:   if (cnt == '0) begin
                      st_n  = ST_HOLD;
                      cnt_n = CW'(CHR_CYC - 1);
                   end
         ST_HOLD:  if (cnt == '0) begin
                      st_n  = ST_RASLO;
                      cnt_n = CW'(RASO_CYC - 1);
                   end
         ST_RASLO: if (cnt == '0) begin
                      st_n  = ST_PRE;
                      cnt_n = CW'(RP_CYC - 1);
                   end
         ST_PRE:   if (cnt == '0) st_n = ST_DONE;
         ST_DONE:  st_n = ST_IDLE;
         default:  st_n = ST_PWR;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_PWR;
         cnt       <= '0;
         ras_q     <= 1'b1;
         cas_q     <= 1'b1;
         req_q     <= 1'b0;
         init_left <= IW'(INIT_CYCLES);
      end else begin
         st    <= st_n;
         cnt   <= cnt_n;
         ras_q <= !(st_n == ST_HOLD || st_n == ST_RASLO);
         cas_q <= !(st_n == ST_CBR  || st_n == ST_HOLD);
         req_q <= (st_n != ST_PWR) && (st_n != ST_IDLE);
         if (st == ST_DONE && init_left != '0)
            init_left <= init_left - 1'b1;
      end
   end

   assign in_pwr   = (st == ST_PWR);
   assign req      = req_q;
   assign ras_n    = ras_q;
   assign cas_n    = cas_q;
   assign ready    = (init_left == '0);
   assign svc_done = (st == ST_DONE) && (init_left == '0);
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
   import drs_pkg::*;
#(
   parameter int CLK_NS      = 5,
   parameter int SPEED_GRADE = 0,
   parameter int POWERUP_NS  = 200000,
   parameter int INIT_CYCLES = 8,
   parameter int REFRESH_NS  = 15625,
   parameter int PEND_DEPTH  = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_grant,
   output logic refresh_req,
   output logic ras_n,
   output logic cas_n,
   output logic we_n,
   output logic array_ready,
   output logic backlog_overflow
);
   localparam int PWR_CYC  = ns_to_cyc(POWERUP_NS, CLK_NS);
   localparam int REF_CYC  = ns_to_cyc(REFRESH_NS, CLK_NS);
   localparam int CSR_CYC  = ns_to_cyc(T_CSR_NS, CLK_NS);
   localparam int CHR_CYC  = ns_to_cyc(t_chr_ns(SPEED_GRADE), CLK_NS);
   localparam int RAS_CYC  = ns_to_cyc(t_ras_ns(SPEED_GRADE), CLK_NS);
   localparam int RP_NS    = (t_rp_ns(SPEED_GRADE) > T_RPC_NS) ? t_rp_ns(SPEED_GRADE) : T_RPC_NS;
   localparam int RP_CYC   = ns_to_cyc(RP_NS, CLK_NS);
   localparam int RASO_CYC = (RAS_CYC > CHR_CYC) ? RAS_CYC - CHR_CYC : 1;

   if (CLK_NS < 1)                     begin : g_bad_clk  $error("CLK_NS must be positive"); end
   if (SPEED_GRADE < 0 || SPEED_GRADE > 1) begin : g_bad_grd $error("SPEED_GRADE must be 0 or 1"); end
   if (INIT_CYCLES < 1)                begin : g_bad_init $error("INIT_CYCLES must be at least 1"); end
   if (PEND_DEPTH < 1)                 begin : g_bad_dep  $error("PEND_DEPTH must be at least 1"); end
   if (PWR_CYC < RP_CYC)               begin : g_bad_pwr  $error("power-up wait shorter than precharge"); end

   logic pwr_done, in_pwr, ref_tick, ref_due, svc_done, ready;

   drs_interval_timer #(.PERIOD(PWR_CYC)) u_pwr_timer (
      .clk(clk), .rst_n(rst_n), .en(in_pwr), .tick(pwr_done)
   );

   drs_interval_timer #(.PERIOD(REF_CYC)) u_ref_timer (
      .clk(clk), .rst_n(rst_n), .en(ready), .tick(ref_tick)
   );

   drs_backlog #(.DEPTH(PEND_DEPTH)) u_backlog (
      .clk(clk), .rst_n(rst_n), .inc(ref_tick), .dec(svc_done),
      .nonzero(ref_due), .overflow(backlog_overflow)
   );

   drs_strobe_fsm #(
      .INIT_CYCLES(INIT_CYCLES), .CSR_CYC(CSR_CYC), .CHR_CYC(CHR_CYC),
      .RASO_CYC(RASO_CYC), .RP_CYC(RP_CYC)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .pwr_done(pwr_done), .ref_due(ref_due),
      .grant(bus_grant), .in_pwr(in_pwr), .req(refresh_req),
      .ras_n(ras_n), .cas_n(cas_n), .ready(ready), .svc_done(svc_done)
   );

   assign array_ready = ready;
   assign we_n        = 1'b1;
endmodule

// File: rtl/drs_checker.sv
module drs_checker #(
   parameter int PWR_CYC     = 40,
   parameter int INIT_CYCLES = 8,
   parameter int CSR_CYC     = 1,
   parameter int CHR_CYC     = 2,
   parameter int RAS_CYC     = 12,
   parameter int RP_CYC      = 8
) (
   input logic clk,
   input logic rst_n,
   input logic bus_grant,
   input logic refresh_req,
   input logic ras_n,
   input logic cas_n,
   input logic we_n,
   input logic array_ready,
   input logic backlog_overflow
);
   logic [15:0] cas_lo, ras_lo, ras_hi;
   logic [31:0] since_rst;
   logic [7:0]  nfall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cas_lo    <= '0;
         ras_lo    <= '0;
         ras_hi    <= '0;
         since_rst <= '0;
         nfall     <= '0;
      end else begin
         cas_lo    <= cas_n ? '0 : ((cas_lo == 16'hFFFF) ? cas_lo : cas_lo + 1'b1);
         ras_lo    <= ras_n ? '0 : ((ras_lo == 16'hFFFF) ? ras_lo : ras_lo + 1'b1);
         ras_hi    <= !ras_n ? '0 : ((ras_hi == 16'hFFFF) ? ras_hi : ras_hi + 1'b1);
         since_rst <= (since_rst == 32'hFFFF_FFFF) ? since_rst : since_rst + 1'b1;
         if (!ras_n && nfall != 8'hFF && ras_lo == '0)
            nfall <= nfall + 1'b1;
      end
   end

   assert_pwr_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst < 32'(PWR_CYC)) |-> !refresh_req);

   assert_init_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(array_ready) |-> (nfall == 8'(INIT_CYCLES)));

   assert_ready_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      array_ready |=> array_ready);

   assert_strobe_granted_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ras_n || !cas_n) |-> (refresh_req && bus_grant));

   assert_req_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(refresh_req) |-> (ras_n && cas_n && $past(ras_n) && $past(cas_n)));

   assert_cas_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> (!cas_n && cas_lo >= 16'(CSR_CYC)));

   assert_cas_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cas_n) && !ras_n) |-> (ras_lo >= 16'(CHR_CYC)));

   assert_ras_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_n) |-> (ras_lo >= 16'(RAS_CYC)));

   assert_precharge_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cas_n) |-> (ras_n && ras_hi >= 16'(RP_CYC)));

   assert_we_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
      we_n);

   assert_no_overflow_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
      backlog_overflow |=> backlog_overflow);
endmodule

bind dram_refresh_seq drs_checker #(
   .PWR_CYC(PWR_CYC), .INIT_CYCLES(INIT_CYCLES), .CSR_CYC(CSR_CYC),
   .CHR_CYC(CHR_CYC), .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_grant(bus_grant), .refresh_req(refresh_req),
   .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .array_ready(array_ready),
   .backlog_overflow(backlog_overflow)
);

// File: tb/tb_dram_refresh_seq.sv
module tb_dram_refresh_seq;
   localparam int CLK_NS  = 5;
   localparam int GRADE   = 0;
   localparam int PWR_NS  = 200;
   localparam int INIT_N  = 8;
   localparam int REF_NS  = 500;
   localparam int DEPTH   = 3;

   // expected counts from the requirement arithmetic
   localparam int E_PWR = (PWR_NS + CLK_NS - 1) / CLK_NS;
   localparam int E_REF = (REF_NS + CLK_NS - 1) / CLK_NS;
   localparam int E_CSR = (5 + CLK_NS - 1) / CLK_NS;
   localparam int E_CHR = ((GRADE ? 15 : 10) + CLK_NS - 1) / CLK_NS;
   localparam int E_RAS = ((GRADE ? 70 : 60) + CLK_NS - 1) / CLK_NS;
   localparam int E_RP  = ((GRADE ? 50 : 40) + CLK_NS - 1) / CLK_NS;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_grant = 1'b0;
   logic refresh_req, ras_n, cas_n, we_n, array_ready, backlog_overflow;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #(2.5) clk = ~clk;

   dram_refresh_seq #(
      .CLK_NS(CLK_NS), .SPEED_GRADE(GRADE), .POWERUP_NS(PWR_NS),
      .INIT_CYCLES(INIT_N), .REFRESH_NS(REF_NS), .PEND_DEPTH(DEPTH)
   ) dut (
      .clk(clk), .rst_n(rst_n), .bus_grant(bus_grant), .refresh_req(refresh_req),
      .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .array_ready(array_ready),
      .backlog_overflow(backlog_overflow)
   );

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   // strobe monitor, sampled on the falling clock edge
   int  falls = 0;
   int  cas_lo_run = 0, ras_lo_run = 0, ras_hi_run = 1000;
   int  we_bad = 0, ungranted = 0;
   bit  p_ras = 1'b1, p_cas = 1'b1;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!we_n) we_bad++;
         if ((!ras_n || !cas_n) && !(refresh_req && bus_grant)) ungranted++;
         if (p_ras && !ras_n) begin
            falls++;
            chk(!cas_n && cas_lo_run >= E_CSR, "R5", cas_lo_run, E_CSR);
         end
         if (!p_ras && !p_cas && cas_n && !ras_n)
            chk(ras_lo_run >= E_CHR, "R6", ras_lo_run, E_CHR);
         if (!p_ras && ras_n)
            chk(ras_lo_run >= E_RAS, "R7", ras_lo_run, E_RAS);
         if (p_cas && !cas_n)
            chk(ras_hi_run >= E_RP, "R8", ras_hi_run, E_RP);
         cas_lo_run = cas_n ? 0 : cas_lo_run + 1;
         ras_lo_run = ras_n ? 0 : ras_lo_run + 1;
         ras_hi_run = ras_n ? ras_hi_run + 1 : 0;
         p_ras = ras_n;
         p_cas = cas_n;
      end
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : main
      int cyc;
      int f0;
      repeat (4) @(negedge clk);
      // R1 reset state
      chk(ras_n && cas_n && we_n, "R1 strobes", {ras_n, cas_n, we_n}, 7);
      chk(!refresh_req && !array_ready && !backlog_overflow, "R1 flags",
          {refresh_req, array_ready, backlog_overflow}, 0);
      rst_n = 1'b1;

      // R2 power-up wait
      cyc = 0;
      while (!refresh_req && cyc < 400) begin
         @(negedge clk);
         cyc++;
      end
      chk(cyc > E_PWR && cyc <= E_PWR + 4, "R2", cyc, E_PWR + 2);

      // R4 no strobes while the bus is withheld
      repeat (20) @(negedge clk);
      chk(ras_n && cas_n && falls == 0 && refresh_req, "R4 withheld", falls, 0);

      // R3 initialization burst
      bus_grant = 1'b1;
      while (!array_ready) @(negedge clk);
      chk(falls == INIT_N, "R3 init count", falls, INIT_N);

      // R10 periodic rate
      f0 = falls;
      repeat (10 * E_REF) @(negedge clk);
      chk((falls - f0) >= 9 && (falls - f0) <= 11, "R10 rate", falls - f0, 10);
      chk(array_ready, "R3 ready sticky", array_ready, 1);

      // R11 backlog of two intervals
      while (refresh_req) @(negedge clk);
      bus_grant = 1'b0;
      while (!refresh_req) @(negedge clk);
      f0 = falls;
      repeat (E_REF + 10) @(negedge clk);
      chk(falls == f0, "R4 no strobe without grant", falls - f0, 0);
      bus_grant = 1'b1;
      repeat (60) @(negedge clk);
      chk(falls - f0 == 2, "R11 backlog drained", falls - f0, 2);
      chk(!backlog_overflow, "R11 no overflow", backlog_overflow, 0);

      // R12 saturation and sticky overflow
      while (refresh_req) @(negedge clk);
      bus_grant = 1'b0;
      while (!refresh_req) @(negedge clk);
      f0 = falls;
      repeat (3 * E_REF + 10) @(negedge clk);
      chk(backlog_overflow, "R12 overflow set", backlog_overflow, 1);
      bus_grant = 1'b1;
      repeat (80) @(negedge clk);
      chk(falls - f0 == DEPTH, "R12 saturated count", falls - f0, DEPTH);
      repeat (3 * E_REF) @(negedge clk);
      chk(backlog_overflow, "R12 overflow sticky", backlog_overflow, 1);

      // R9 and R4 whole-run monitors
      chk(we_bad == 0, "R9 we high", we_bad, 0);
      chk(ungranted == 0, "R4 strobes granted", ungranted, 0);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule